// File: doc/BRIEF.md
# Multiplexed-Bus DMA Burst Sequencer

This block moves buffers of data across a 16-bit bus that carries both addresses and data. Each buffer is moved as a fixed number of bursts. A burst is a single address cycle followed by a fixed number of data cycles. A separate link-level ready input paces the individual data cycles. When one buffer is finished, the sequencer leaves the bus quiet for a programmable switching interval before it will open the next buffer.

A DMA request pin is driven from a buffer watermark input, separately from the link handshake. The request is registered, its polarity is chosen by a configuration input, and it is held inactive during the buffer-switching interval. Transfer direction is taken when a buffer starts. In a write transfer the block drives host data onto the bus in the data cycles. In a read transfer it releases the bus and raises a strobe for each accepted data cycle.

Top module: `mbus_dma_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, addr_phase, ad_oe and beat_strobe are 0, ad_out is 0, bus_wr is 0 and drq is inactive (drq equals the inverse of drq_high).
- R2: In an idle cycle with buf_ready high, the next cycle is an address cycle: addr_phase=1, ad_oe=1, and ad_out = base_addr + k*BEATS (mod 2^16) for the k-th burst of the buffer, counting k from 0.
- R3: An address cycle lasts exactly one cycle. It is followed by data cycles, and the next address cycle comes only after exactly BEATS beat_strobe pulses.
- R4: In a data cycle with link_rdy low, beat_strobe is 0 and the cycle repeats with the bus contents unchanged. With link_rdy high, beat_strobe is 1 and the beat is taken.
- R5: A buffer consists of exactly BURSTS bursts (BURSTS*BEATS beats) before the switching interval.
- R6: After the last beat of a buffer, addr_phase and ad_oe stay 0 for exactly GAP+1 cycles when buf_ready is held high. The next address cycle follows those cycles.
- R7: In write data cycles (bus_wr=1), ad_oe=1 and ad_out=wr_data. In read data cycles (bus_wr=0), ad_oe=0 and ad_out=0.
- R8: drq follows wmark one cycle later. It is active-high when drq_high=1 and active-low when drq_high=0.
- R9: drq is inactive in every cycle that follows a switching-interval cycle, whatever wmark is.
- R10: wr_sel is sampled only when a buffer starts (bus_wr=1 means write). Changes to wr_sel during a buffer do not change bus_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq_high | input | 1 | Request polarity: 1 gives active-high, 0 gives active-low |
| wmark | input | 1 | Buffer watermark condition |
| buf_ready | input | 1 | A buffer is ready to be moved |
| wr_sel | input | 1 | Direction for the next buffer: 1 is write, 0 is read |
| link_rdy | input | 1 | Link-level ready that paces data cycles |
| base_addr | input | 16 | Start address of the buffer |
| wr_data | input | 16 | Write data for the current beat |
| ad_out | output | 16 | Value driven on the multiplexed bus |
| ad_oe | output | 1 | Bus output enable |
| addr_phase | output | 1 | The current cycle is an address cycle |
| bus_wr | output | 1 | Direction of the current buffer |
| beat_strobe | output | 1 | A data beat is taken this cycle |
| drq | output | 1 | DMA request, polarity set by drq_high |

## Verification
The hardest case to reach is the switching interval with the watermark held asserted and a new buffer already pending. In that case the request suppression and the exact idle length can both be seen. A directed sequence holds buf_ready, link_rdy and wmark high through a whole buffer, then counts the quiet cycles and samples drq inside them. Long link stalls in a write burst and a direction change in the middle of a buffer are also driven directly. Random traffic with occasional resets and polarity flips is compared cycle by cycle against a model in the bench.

// File: rtl/mbus_dma_seq.sv
module mbus_dma_seq #(
  parameter int BEATS  = 16,
  parameter int BURSTS = 4,
  parameter int GAP    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drq_high,
  input  logic        wmark,
  input  logic        buf_ready,
  input  logic        wr_sel,
  input  logic        link_rdy,
  input  logic [15:0] base_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] ad_out,
  output logic        ad_oe,
  output logic        addr_phase,
  output logic        bus_wr,
  output logic        beat_strobe,
  output logic        drq
);
  localparam int BW = $clog2(BEATS + 1);
  localparam int NW = $clog2(BURSTS + 1);
  localparam int GW = $clog2(GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_GAP} st_t;

  st_t           st;
  logic [BW-1:0] beat;
  logic [NW-1:0] burst;
  logic [GW-1:0] gcnt;
  logic          dir;
  logic          drq_act;

  wire last_beat  = (beat == BW'(BEATS - 1));
  wire last_burst = (burst == NW'(BURSTS - 1));
  wire [15:0] burst_off = 16'(burst * BEATS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      beat    <= '0;
      burst   <= '0;
      gcnt    <= '0;
      dir     <= 1'b0;
      drq_act <= 1'b0;
    end else begin
      drq_act <= wmark && (st != S_GAP);
      case (st)
        S_IDLE: if (buf_ready) begin
          st    <= S_ADDR;
          dir   <= wr_sel;
          burst <= '0;
        end
        S_ADDR: begin
          st   <= S_DATA;
          beat <= '0;
        end
        S_DATA: if (link_rdy) begin
          if (last_beat) begin
            beat <= '0;
            if (last_burst) begin
              st   <= S_GAP;
              gcnt <= '0;
            end else begin
              burst <= burst + 1'b1;
              st    <= S_ADDR;
            end
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: begin
          if (gcnt == GW'(GAP - 1)) st <= S_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
      endcase
    end
  end

  assign addr_phase  = (st == S_ADDR);
  assign ad_oe       = (st == S_ADDR) || ((st == S_DATA) && dir);
  assign ad_out      = (st == S_ADDR) ? base_addr + burst_off :
                       ((st == S_DATA) && dir) ? wr_data : 16'h0000;
  assign bus_wr      = dir;
  assign beat_strobe = (st == S_DATA) && link_rdy;
  assign drq         = drq_high ? drq_act : ~drq_act;

  a_r3_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);
  a_r3_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR) |=> (st == S_DATA) && (beat == '0));
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !link_rdy) |=> (st == S_DATA) && $stable(beat) && $stable(burst));
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (burst < NW'(BURSTS)) && (beat < BW'(BEATS)));
  a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> !ad_oe && !addr_phase && !beat_strobe);
  a_r9_no_drq_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |=> !drq_act);
  a_r10_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(dir));
endmodule

// File: tb/mbus_dma_seq_test.sv
module mbus_dma_seq_test;
  localparam int BEATS = 16, BURSTS = 4, GAP = 2;

  logic clk = 0, rst_n = 0, drq_high = 0, wmark = 0, buf_ready = 0, wr_sel = 0, link_rdy = 0;
  logic [15:0] base_addr = 16'h1000, wr_data = 0;
  logic [15:0] ad_out;
  logic ad_oe, addr_phase, bus_wr, beat_strobe, drq;

  int checks = 0, errors = 0;
  int m_st = 0, m_beat = 0, m_burst = 0, m_g = 0;
  logic m_dir = 0, m_act = 0;

  always #2 clk = ~clk;

  mbus_dma_seq #(.BEATS(BEATS), .BURSTS(BURSTS), .GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .drq_high(drq_high), .wmark(wmark), .buf_ready(buf_ready),
    .wr_sel(wr_sel), .link_rdy(link_rdy), .base_addr(base_addr), .wr_data(wr_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_phase(addr_phase), .bus_wr(bus_wr),
    .beat_strobe(beat_strobe), .drq(drq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_ad();
    if (m_st == 1) return 16'(base_addr + 16'(m_burst * BEATS));
    if (m_st == 2 && m_dir) return wr_data;
    return 16'h0;
  endfunction

  task automatic step();
    #1;
    chk(rst_n ? "R2/R7 ad_out" : "R1 ad_out", ad_out, exp_ad());
    chk(rst_n ? "R3 addr_phase" : "R1 addr_phase", 16'(addr_phase), 16'(m_st == 1));
    chk(rst_n ? "R7 ad_oe" : "R1 ad_oe", 16'(ad_oe), 16'(m_st == 1 || (m_st == 2 && m_dir)));
    chk(rst_n ? "R4 beat_strobe" : "R1 beat_strobe", 16'(beat_strobe), 16'(m_st == 2 && link_rdy));
    chk(rst_n ? "R8 drq" : "R1 drq", 16'(drq), 16'(drq_high ? m_act : !m_act));
    chk(rst_n ? "R10 bus_wr" : "R1 bus_wr", 16'(bus_wr), 16'(m_dir));
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_burst = 0; m_g = 0; m_dir = 0; m_act = 0;
    end else begin
      m_act = wmark && (m_st != 3);
      case (m_st)
        0: if (buf_ready) begin m_st = 1; m_dir = wr_sel; m_burst = 0; end
        1: begin m_st = 2; m_beat = 0; end
        2: if (link_rdy) begin
             if (m_beat == BEATS - 1) begin
               m_beat = 0;
               if (m_burst == BURSTS - 1) begin m_st = 3; m_g = 0; end
               else begin m_burst++; m_st = 1; end
             end else m_beat++;
           end
        default: if (m_g == GAP - 1) m_st = 0; else m_g++;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int strobes, addrs, idle;
    void'($urandom(32'd7321));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();       // R1 during reset
    rst_n = 1;
    step();                                    // R1 first cycle after reset

    // R5 / R6 / R9: whole buffer with everything held high
    buf_ready = 1; link_rdy = 1; wmark = 1; wr_sel = 1; wr_data = 16'hA5A5;
    step();                                    // idle cycle, buffer starts
    strobes = 0; addrs = 0;
    for (int i = 0; i < BURSTS * (BEATS + 1); i++) begin
      #1;
      strobes += beat_strobe; addrs += addr_phase;
      step();
    end
    chk("R5 beats per buffer", 16'(strobes), 16'(BURSTS * BEATS));
    chk("R5 bursts per buffer", 16'(addrs), 16'(BURSTS));
    idle = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (addr_phase) break;
      if (i == 1) chk("R9 drq inactive after gap cycle", 16'(drq), 16'(1));
      chk("R6 bus quiet", 16'(ad_oe), 16'(0));
      idle++;
      step();
    end
    chk("R6 quiet cycles", 16'(idle), 16'(GAP + 1));

    // R4 / R10: stall in a write data cycle, then flip direction request
    step();                                    // address cycle
    wr_data = 16'h3C3C; link_rdy = 0;
    for (int i = 0; i < 10; i++) begin
      #1;
      chk("R4 stall no strobe", 16'(beat_strobe), 16'(0));
      chk("R4 stall bus held", ad_out, 16'h3C3C);
      step();
    end
    link_rdy = 1; wr_sel = 0;
    #1; chk("R4 resume strobe", 16'(beat_strobe), 16'(1));
    for (int i = 0; i < 8; i++) begin
      step();
      #1; chk("R10 direction held", 16'(bus_wr), 16'(1));
    end
    step();

    // random traffic
    for (int n = 0; n < 20000; n++) begin
      buf_ready = ($urandom % 2) == 0;
      link_rdy  = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) wmark = ~wmark;
      if ($urandom % 500 == 0) drq_high = ~drq_high;
      if ($urandom % 300 == 0) base_addr = 16'($urandom);
      wr_sel  = $urandom % 2;
      wr_data = 16'($urandom);
      rst_n   = ($urandom % 2000) != 0;
      step();
    end
    rst_n = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule